// File: doc/BRIEF.md
# TDM Frame Timing Recovery

This block recovers frame timing for a time-division-multiplexed serial interface. A bit clock and an 8 kHz frame pulse arrive from off-chip, asynchronous to the system clock. The block resynchronises both into the system clock domain and counts bit clock sampling edges. It places the frame boundary on the sampling edge that the configured framing convention defines. At each boundary it emits a one-cycle `frame_start` strobe and resets the bit position counter. Downstream stream receivers use that counter to locate channel and bit slots.

Three configuration inputs select the framing convention. The first sets the polarity of the frame pulse. The second selects the GCI-style pulse format. The third chooses which bit clock edge is the sampling edge. A two-bit rate code names the bit clock frequency, 4.096, 8.192 or 16.384 MHz, and so sets how many bit clocks a frame holds. After the first boundary has been seen, any boundary that arrives after a different number of sampling edges raises a sticky error flag.

The framing logic is a three-state machine, and its states and transitions are named here:
- `ST_WAIT_IDLE` is the state after reset. A sampling edge that sees the pulse inactive moves it to `ST_ARMED`.
- `ST_ARMED` moves to `ST_IN_PULSE` on a sampling edge that sees the pulse active. In the standard format this edge is the frame boundary.
- `ST_IN_PULSE` returns to `ST_ARMED` on a sampling edge that sees the pulse inactive. In GCI format this edge is the frame boundary.

Top module: `tdm_frame_align`

## Requirements
- R1: While reset is asserted and right after it, `frame_start`, `bit_count`, `frame_locked` and `frame_error` are all zero.
- R2: `bit_count` increases by one on every sampling edge of the bit clock and is unchanged by the other edge. With `cfg_rising_edge`=0 the sampling edge is the falling edge; with `cfg_rising_edge`=1 it is the rising edge.
- R3: With `cfg_gci_mode`=0, the frame boundary is the first sampling edge that sees the pulse active after a sampling edge that saw it inactive. The pulse is active-low when `cfg_pulse_high`=0 and active-high when `cfg_pulse_high`=1.
- R4: With `cfg_gci_mode`=1, the pulse is active-high whatever `cfg_pulse_high` holds. The frame boundary is the first sampling edge that sees the pulse inactive after a sampling edge that saw it active.
- R5: On a frame boundary, `bit_count` becomes 0 and `frame_start` is high for exactly one system clock cycle.
- R6: `frame_locked` rises with the first frame boundary after reset and stays high until reset.
- R7: The expected frame length is BASE_LEN sampling edges for `cfg_rate`=0, 2*BASE_LEN for 1, and 4*BASE_LEN for 2 or 3. A boundary that arrives while `frame_locked` is high and `bit_count` differs from length-1, whether early or late, sets `frame_error`.
- R8: Once set, `frame_error` stays set through later correct frames until reset.
- R9: After reset, a pulse that is already active produces no boundary until at least one sampling edge has seen it inactive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| bit_clk_pin | input | 1 | Asynchronous bit clock |
| frame_pulse_pin | input | 1 | Asynchronous 8 kHz frame pulse |
| cfg_pulse_high | input | 1 | 1: pulse active-high in standard format |
| cfg_gci_mode | input | 1 | 1: GCI pulse format |
| cfg_rising_edge | input | 1 | 1: rising edge is the sampling edge |
| cfg_rate | input | 2 | Bit clock rate code (0, 1, 2/3) |
| frame_start | output | 1 | One-cycle strobe at each frame boundary |
| bit_count | output | $clog2(4*BASE_LEN)+1 | Sampling edges since the last boundary |
| frame_locked | output | 1 | First boundary seen since reset |
| frame_error | output | 1 | Sticky frame-length mismatch |

## Verification
Suppose the state machine holds the wrong state, for example `ST_IN_PULSE` where it should be armed. The port view is then either a missing `frame_start` or a strobe moved by the pulse width. Such a fault is visible within one frame, and by the next frame it also shows as a false `frame_error`. A counter that skips or repeats an edge shows up at the next boundary, where the last count seen before the strobe differs from length-1. Sampling on the wrong edge shows up as soon as a single bit clock transition has crossed the synchronizer, about three system cycles later.

// File: rtl/tdm_fa_pkg.sv
package tdm_fa_pkg;

    typedef enum logic [1:0] {
        ST_WAIT_IDLE = 2'd0,
        ST_ARMED     = 2'd1,
        ST_IN_PULSE  = 2'd2
    } fa_state_e;

    // sampling edges per 125 us frame for a given rate code
    function automatic int unsigned frame_len(input int unsigned base, input logic [1:0] rate);
        unique case (rate)
            2'd0:    return base;
            2'd1:    return base * 2;
            default: return base * 4;
        endcase
    endfunction

endpackage

// File: rtl/tdm_fa_sync.sv
module tdm_fa_sync #(
    parameter int unsigned W = 2
) (
    input  logic         clk,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    // two-flop synchronizer per bit; no reset so reset release sees no edge
    for (genvar i = 0; i < W; i++) begin : g_bit
        logic s1, s2;
        always_ff @(posedge clk) begin
            s1 <= d[i];
            s2 <= s1;
        end
        assign q[i] = s2;
    end
endmodule

// File: rtl/tdm_fa_edge_sel.sv
module tdm_fa_edge_sel (
    input  logic clk,
    input  logic bclk_s,
    input  logic fp_s,
    input  logic cfg_rising_edge,
    input  logic active_high,
    output logic samp,
    output logic fp_active
);
    logic bclk_prev;

    always_ff @(posedge clk) begin
        bclk_prev <= bclk_s;
    end

    logic rise_ev, fall_ev;
    always_comb begin
        rise_ev   = bclk_s & ~bclk_prev;
        fall_ev   = ~bclk_s & bclk_prev;
        samp      = cfg_rising_edge ? rise_ev : fall_ev;
        fp_active = (fp_s == active_high);
    end
endmodule

// File: rtl/tdm_fa_fsm.sv
module tdm_fa_fsm
    import tdm_fa_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic samp,
    input  logic fp_active,
    input  logic gci_mode,
    output logic boundary
);
    fa_state_e state_q, state_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_WAIT_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_WAIT_IDLE: if (samp && !fp_active) state_d = ST_ARMED;
            ST_ARMED:     if (samp &&  fp_active) state_d = ST_IN_PULSE;
            ST_IN_PULSE:  if (samp && !fp_active) state_d = ST_ARMED;
            default:      state_d = ST_WAIT_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        boundary = 1'b0;
        unique case (state_q)
            ST_WAIT_IDLE: boundary = 1'b0;
            ST_ARMED:     boundary = samp &&  fp_active && !gci_mode;
            ST_IN_PULSE:  boundary = samp && !fp_active &&  gci_mode;
            default:      boundary = 1'b0;
        endcase
    end
endmodule

// File: rtl/tdm_frame_align.sv
module tdm_frame_align
    import tdm_fa_pkg::*;
#(
    parameter  int unsigned BASE_LEN = 512,
    localparam int unsigned CNT_W    = $clog2(BASE_LEN * 4) + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_clk_pin,
    input  logic             frame_pulse_pin,
    input  logic             cfg_pulse_high,
    input  logic             cfg_gci_mode,
    input  logic             cfg_rising_edge,
    input  logic [1:0]       cfg_rate,
    output logic             frame_start,
    output logic [CNT_W-1:0] bit_count,
    output logic             frame_locked,
    output logic             frame_error
);
    logic [1:0] pins_s;
    logic       samp, fp_active, boundary;
    logic [CNT_W-1:0] last_idx;

    tdm_fa_sync #(.W(2)) u_sync (
        .clk (clk),
        .d   ({bit_clk_pin, frame_pulse_pin}),
        .q   (pins_s)
    );

    tdm_fa_edge_sel u_edge (
        .clk             (clk),
        .bclk_s          (pins_s[1]),
        .fp_s            (pins_s[0]),
        .cfg_rising_edge (cfg_rising_edge),
        .active_high     (cfg_pulse_high | cfg_gci_mode),
        .samp            (samp),
        .fp_active       (fp_active)
    );

    tdm_fa_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .samp      (samp),
        .fp_active (fp_active),
        .gci_mode  (cfg_gci_mode),
        .boundary  (boundary)
    );

    always_comb begin
        last_idx = CNT_W'(frame_len(BASE_LEN, cfg_rate) - 1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            frame_start  <= 1'b0;
            bit_count    <= '0;
            frame_locked <= 1'b0;
            frame_error  <= 1'b0;
        end else begin
            frame_start <= samp && boundary;
            if (samp) begin
                if (boundary) begin
                    bit_count    <= '0;
                    frame_locked <= 1'b1;
                    if (frame_locked && (bit_count != last_idx))
                        frame_error <= 1'b1;
                end else begin
                    bit_count <= bit_count + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/tdm_frame_align_chk.sv
module tdm_frame_align_chk #(
    parameter  int unsigned BASE_LEN = 512,
    localparam int unsigned CNT_W    = $clog2(BASE_LEN * 4) + 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             frame_start,
    input logic [CNT_W-1:0] bit_count,
    input logic             frame_locked,
    input logic             frame_error
);
    a_r5_start_single: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> !frame_start);

    a_r5_count_zero: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |-> (bit_count == '0));

    a_r6_locked_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        frame_locked |=> frame_locked);

    a_r6_start_locked: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |-> frame_locked);

    a_r7_error_after_lock: assert property (@(posedge clk) disable iff (!rst_n)
        frame_error |-> frame_locked);

    a_r8_error_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        frame_error |=> frame_error);

    a_r2_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(bit_count) |->
            ((bit_count == $past(bit_count) + CNT_W'(1)) || (bit_count == '0)));
endmodule

bind tdm_frame_align tdm_frame_align_chk #(.BASE_LEN(BASE_LEN)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .frame_start  (frame_start),
    .bit_count    (bit_count),
    .frame_locked (frame_locked),
    .frame_error  (frame_error)
);

// File: tb/tdm_frame_align_tb.sv
module tdm_frame_align_tb;
    localparam int unsigned BASE  = 16;
    localparam int unsigned CW    = $clog2(BASE * 4) + 1;
    localparam int          NROWS = 10;

    // vector: [15]pol [14]gci [13]rise [12:11]rate [10:3]len [2:1]width [0]exp_err
    function automatic bit [15:0] mk(input bit pol, input bit gci, input bit rise,
                                     input bit [1:0] rate, input int len, input int w,
                                     input bit err);
        bit [7:0] l8;
        bit [1:0] w2;
        l8 = len[7:0];
        w2 = w[1:0];
        return {pol, gci, rise, rate, l8, w2, err};
    endfunction

    localparam bit [15:0] VEC [NROWS] = '{
        mk(0, 0, 0, 2'd0, 16, 1, 0),
        mk(1, 0, 0, 2'd0, 16, 2, 0),
        mk(0, 0, 1, 2'd1, 32, 1, 0),
        mk(1, 0, 1, 2'd2, 64, 1, 0),
        mk(0, 1, 0, 2'd0, 16, 2, 0),
        mk(1, 1, 1, 2'd1, 32, 1, 0),
        mk(0, 0, 0, 2'd3, 64, 1, 0),
        mk(0, 0, 0, 2'd0, 15, 1, 1),
        mk(1, 1, 0, 2'd1, 33, 1, 1),
        mk(0, 0, 0, 2'd2, 32, 1, 1)
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bclk_pin = 1'b1;
    logic          fp_pin = 1'b1;
    logic          cfg_pol = 1'b0, cfg_gci = 1'b0, cfg_rise = 1'b0;
    logic [1:0]    cfg_rate = 2'd0;
    logic          frame_start, frame_locked, frame_error;
    logic [CW-1:0] bit_count;

    logic rise_q = 1'b0;
    logic act_q  = 1'b0;

    int n_checks = 0, n_fail = 0;
    int mon_checks = 0, mon_fail = 0;
    int starts_total = 0;
    int last_before = 0;
    int prev_cnt = 0;
    logic prev_fs = 1'b0;

    always #4 clk = ~clk;

    tdm_frame_align #(.BASE_LEN(BASE)) u_dut (
        .clk             (clk),
        .rst_n           (rst_n),
        .bit_clk_pin     (bclk_pin),
        .frame_pulse_pin (fp_pin),
        .cfg_pulse_high  (cfg_pol),
        .cfg_gci_mode    (cfg_gci),
        .cfg_rising_edge (cfg_rise),
        .cfg_rate        (cfg_rate),
        .frame_start     (frame_start),
        .bit_count       (bit_count),
        .frame_locked    (frame_locked),
        .frame_error     (frame_error)
    );

    // monitor: R5 checks at every strobe, records count seen before it
    always @(negedge clk) begin
        if (rst_n) begin
            if (frame_start) begin
                starts_total <= starts_total + 1;
                last_before  <= prev_cnt;
                mon_checks   <= mon_checks + 2;
                if (bit_count != '0) begin
                    mon_fail <= mon_fail + 1;
                    $display("FAIL R5 count at strobe actual=%0d expected=0", bit_count);
                end
                if (prev_fs) begin
                    mon_fail <= mon_fail + 1;
                    $display("FAIL R5 strobe width actual=2+ expected=1");
                end
            end
        end
        prev_cnt <= int'(bit_count);
        prev_fs  <= frame_start;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (6) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic half_bit();
        repeat (4) @(negedge clk);
    endtask

    // one bit slot: sampling edge, then set pulse for the next slot at the other edge
    task automatic slot(input bit nxt_active);
        bclk_pin = rise_q;
        half_bit();
        fp_pin   = nxt_active ? act_q : ~act_q;
        bclk_pin = ~rise_q;
        half_bit();
    endtask

    task automatic run_frames(input int len, input int w, input int nf);
        for (int p = 0; p < 3; p++) slot(1'b0);
        slot(1'b1);
        for (int f = 0; f < nf; f++) begin
            for (int k = 0; k < len; k++) begin
                if (k + 1 < len) slot((k + 1) < w);
                else             slot(f < nf - 1);
            end
        end
        repeat (8) @(negedge clk);
    endtask

    task automatic setup(input bit pol, input bit gci, input bit rise, input bit [1:0] rate);
        cfg_pol  = pol;
        cfg_gci  = gci;
        cfg_rise = rise;
        cfg_rate = rate;
        rise_q   = rise;
        act_q    = pol | gci;
        bclk_pin = ~rise;
        fp_pin   = ~(pol | gci);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d",
                 n_checks + mon_checks + 1, n_fail + mon_fail + 1);
        $finish;
    end

    initial begin : main
        int s0;
        setup(0, 0, 0, 2'd0);
        do_reset();
        // R1 reset state
        check(frame_start == 1'b0,  "R1 frame_start", frame_start, 0);
        check(bit_count == '0,      "R1 bit_count", bit_count, 0);
        check(frame_locked == 1'b0, "R1 frame_locked", frame_locked, 0);
        check(frame_error == 1'b0,  "R1 frame_error", frame_error, 0);

        // table of framing conventions: R3 R4 R5 R6 R7
        for (int r = 0; r < NROWS; r++) begin
            bit [15:0] v;
            int len, w;
            v   = VEC[r];
            len = int'(v[10:3]);
            w   = int'(v[2:1]);
            setup(v[15], v[14], v[13], v[12:11]);
            do_reset();
            s0 = starts_total;
            run_frames(len, w, 3);
            check(starts_total - s0 == 3, v[14] ? "R4 boundaries" : "R3 boundaries",
                  starts_total - s0, 3);
            check(last_before == len - 1, "R2 count before strobe", last_before, len - 1);
            check(frame_locked == 1'b1, "R6 locked", frame_locked, 1);
            check(frame_error == v[0], "R7 length error", frame_error, v[0]);
        end

        // R2 falling edge is sampling edge, rising ignored
        setup(0, 0, 0, 2'd0);
        do_reset();
        bclk_pin = 1'b0; repeat (8) @(negedge clk);
        check(bit_count == CW'(1), "R2 falling counts", bit_count, 1);
        bclk_pin = 1'b1; repeat (8) @(negedge clk);
        check(bit_count == CW'(1), "R2 rising ignored", bit_count, 1);

        // R2 rising edge selected
        setup(0, 0, 1, 2'd0);
        do_reset();
        bclk_pin = 1'b1; repeat (8) @(negedge clk);
        check(bit_count == CW'(1), "R2 rising counts", bit_count, 1);
        bclk_pin = 1'b0; repeat (8) @(negedge clk);
        check(bit_count == CW'(1), "R2 falling ignored", bit_count, 1);

        // R9 pulse active from reset gives no boundary
        setup(0, 0, 0, 2'd0);
        fp_pin = act_q;
        do_reset();
        s0 = starts_total;
        for (int i = 0; i < 5; i++) slot(1'b1);
        repeat (8) @(negedge clk);
        check(starts_total == s0, "R9 no boundary", starts_total - s0, 0);
        check(frame_locked == 1'b0, "R9 not locked", frame_locked, 0);
        slot(1'b0);
        slot(1'b1);
        slot(1'b0);
        repeat (8) @(negedge clk);
        check(starts_total - s0 == 1, "R9 boundary after idle", starts_total - s0, 1);

        // R8 sticky error through good frames
        setup(0, 0, 0, 2'd0);
        do_reset();
        run_frames(15, 1, 3);
        check(frame_error == 1'b1, "R7 early frame", frame_error, 1);
        run_frames(16, 1, 3);
        check(frame_error == 1'b1, "R8 sticky", frame_error, 1);
        do_reset();
        check(frame_error == 1'b0, "R1 error cleared", frame_error, 0);
        check(frame_locked == 1'b0, "R1 lock cleared", frame_locked, 0);

        repeat (4) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d",
                 n_checks + mon_checks, n_fail + mon_fail);
        $finish;
    end
endmodule